// File: doc/BRIEF.md
# Banked Multi-Width Register File

This block holds sixteen 16-bit general registers and lets the surrounding datapath see them at four widths. A byte view covers the two halves of the first eight registers, a word view covers all sixteen, a 32-bit view joins an even register with the odd one after it, and a 64-bit view joins four registers that start on a multiple of four. Each width has its own combinational read port and its own write port. All of them can be used in the same cycle, and a fixed order settles any overlap between them. Two further write commands widen a sign: one spreads it across a pair and the other across a quad.

The block also keeps two banked copies of the stack state: one for privileged (system) operation and one for normal operation. Each copy holds a 16-bit stack pointer and a 7-bit segment number. The `sys_mode` input follows the mode bit of the processor's control word. When that bit changes, the block stores the live R15 and the segment field of R14 into the copy for the mode being left. In the same clock edge it loads R15 and R14 from the copy for the mode being entered.

Top module: `mwreg_bank`

## Requirements
- R1: Reset (active-low `rst_n`) clears all sixteen registers and both banked stack-pointer and segment copies to zero.
- R2: A byte read index selects register R0..R7 with its bits 2:0. Its bit 3 picks the half: 0 = bits 15:8 and 1 = bits 7:0.
- R3: A byte write replaces only the selected half of the selected register, and the other half keeps its value.
- R4: Any of the sixteen registers can be written and read as a whole word.
- R5: A pair at even index n maps R(n) to bits 31:16 and R(n+1) to bits 15:0. A pair write at an odd index changes nothing. A pair read at an odd index returns zero with `rd_pair_bad` = 1, and `rd_pair_bad` is 0 for even indices.
- R6: A quad at index n (n a multiple of 4) maps R(n) to bits 63:48, on down to R(n+3) at bits 15:0. A quad write at any other index changes nothing. A quad read at such an index returns zero with `rd_quad_bad` = 1.
- R7: A word sign-extend at even index n loads R(n) with 0xFFFF when bit 15 of R(n+1) is 1, and with 0x0000 when it is 0. At an odd index the command changes nothing.
- R8: A long sign-extend at quad index n loads R(n) and R(n+1) with copies of bit 15 of R(n+2). A misaligned index changes nothing.
- R9: When `sys_mode` goes from 0 to 1, the normal copy takes R15 and bits 14:8 of R14. R15 is then loaded with the system pointer, and R14 with the system segment in bits 14:8 and zeros elsewhere.
- R10: When `sys_mode` goes from 1 to 0, the system copy takes R15 and bits 14:8 of R14. R15 and R14 are then loaded from the normal copy in the same layout.
- R11: A swap takes effect at the first clock edge that sees the new mode. While the mode does not change, the banked copies are left alone and R14/R15 behave as ordinary registers.
- R12: Reads are combinational from the stored state, so a read of a register that is being written in the same cycle returns the old value.
- R13: When write commands overlap, byte wins over word, word over pair, pair over quad, and quad over the sign-extends. On a swap edge the swap overrides any write to R14/R15, and the value saved is the one held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_mode | input | 1 | Mode bit from control word, 1 = system |
| rd_byte_idx | input | 4 | Byte read index |
| rd_byte_data | output | 8 | Byte read data |
| rd_word_idx | input | 4 | Word read index |
| rd_word_data | output | 16 | Word read data |
| rd_pair_idx | input | 4 | Pair read index |
| rd_pair_data | output | 32 | Pair read data |
| rd_pair_bad | output | 1 | Pair read index is odd |
| rd_quad_idx | input | 4 | Quad read index |
| rd_quad_data | output | 64 | Quad read data |
| rd_quad_bad | output | 1 | Quad read index is misaligned |
| wr_byte_en | input | 1 | Byte write enable |
| wr_byte_idx | input | 4 | Byte write index |
| wr_byte_data | input | 8 | Byte write data |
| wr_word_en | input | 1 | Word write enable |
| wr_word_idx | input | 4 | Word write index |
| wr_word_data | input | 16 | Word write data |
| wr_pair_en | input | 1 | Pair write enable |
| wr_pair_idx | input | 4 | Pair write index |
| wr_pair_data | input | 32 | Pair write data |
| wr_quad_en | input | 1 | Quad write enable |
| wr_quad_idx | input | 4 | Quad write index |
| wr_quad_data | input | 64 | Quad write data |
| sxw_en | input | 1 | Word sign-extend command |
| sxw_idx | input | 4 | Pair index for word sign-extend |
| sxl_en | input | 1 | Long sign-extend command |
| sxl_idx | input | 4 | Quad index for long sign-extend |

## Verification
The properties assume that every enable, index and `sys_mode` holds a known value at each rising edge after reset. They also assume that reset is held over at least one edge. Several properties look at one command in isolation, and they apply only in cycles where no other write port is enabled and the mode bit is steady. The stimulus changes inputs only at falling edges, raises one command at a time except in the deliberate overlap cases, and drops each enable after a single cycle, so these guarded cycles occur often.

// File: rtl/mwrb_pkg.sv
package mwrb_pkg;
    localparam int WORD_W   = 16;
    localparam int REG_N    = 16;
    localparam int IDX_W    = $clog2(REG_N);
    localparam int BYTE_W   = WORD_W / 2;
    localparam int PAIR_W   = 2 * WORD_W;
    localparam int QUAD_N   = 4;
    localparam int QUAD_W   = QUAD_N * WORD_W;
    localparam int SEG_W    = 7;
    localparam int SEG_LSB  = 8;
    localparam int SP_REG   = REG_N - 1;
    localparam int SG_REG   = REG_N - 2;

    typedef logic [WORD_W-1:0]             word_t;
    typedef logic [SEG_W-1:0]              seg_t;
    typedef logic [REG_N-1:0][WORD_W-1:0]  file_t;

    typedef struct packed {
        file_t  regs;
        word_t  sp_sys;
        word_t  sp_nrm;
        seg_t   sg_sys;
        seg_t   sg_nrm;
        logic   sys;
    } bank_t;
endpackage

// File: rtl/mwrb_rd_mux.sv
module mwrb_rd_mux
    import mwrb_pkg::*;
(
    input  file_t                rf,
    input  logic [IDX_W-1:0]     b_idx,
    output logic [BYTE_W-1:0]    b_data,
    input  logic [IDX_W-1:0]     w_idx,
    output logic [WORD_W-1:0]    w_data,
    input  logic [IDX_W-1:0]     p_idx,
    output logic [PAIR_W-1:0]    p_data,
    output logic                 p_bad,
    input  logic [IDX_W-1:0]     q_idx,
    output logic [QUAD_W-1:0]    q_data,
    output logic                 q_bad
);
    word_t bsel;

    always_comb begin
        bsel   = rf[{1'b0, b_idx[IDX_W-2:0]}];
        b_data = b_idx[IDX_W-1] ? bsel[BYTE_W-1:0] : bsel[WORD_W-1:BYTE_W];
        w_data = rf[w_idx];

        p_bad  = p_idx[0];
        p_data = '0;
        if (!p_bad)
            p_data = {rf[{p_idx[IDX_W-1:1], 1'b0}], rf[{p_idx[IDX_W-1:1], 1'b1}]};

        q_bad  = |q_idx[1:0];
        q_data = '0;
        if (!q_bad)
            for (int k = 0; k < QUAD_N; k++)
                q_data[(QUAD_N-1-k)*WORD_W +: WORD_W] = rf[{q_idx[IDX_W-1:2], k[1:0]}];
    end
endmodule

// File: rtl/mwrb_wr_merge.sv
module mwrb_wr_merge
    import mwrb_pkg::*;
(
    input  file_t                rf_q,
    input  logic                 byte_en,
    input  logic [IDX_W-1:0]     byte_idx,
    input  logic [BYTE_W-1:0]    byte_data,
    input  logic                 word_en,
    input  logic [IDX_W-1:0]     word_idx,
    input  logic [WORD_W-1:0]    word_data,
    input  logic                 pair_en,
    input  logic [IDX_W-1:0]     pair_idx,
    input  logic [PAIR_W-1:0]    pair_data,
    input  logic                 quad_en,
    input  logic [IDX_W-1:0]     quad_idx,
    input  logic [QUAD_W-1:0]    quad_data,
    input  logic                 sxw_en,
    input  logic [IDX_W-1:0]     sxw_idx,
    input  logic                 sxl_en,
    input  logic [IDX_W-1:0]     sxl_idx,
    output file_t                rf_w
);
    word_t            sxl_fill;
    word_t            sxw_fill;
    logic [IDX_W-1:0] breg;

    always_comb begin
        rf_w     = rf_q;
        sxl_fill = {WORD_W{rf_q[{sxl_idx[IDX_W-1:2], 2'd2}][WORD_W-1]}};
        sxw_fill = {WORD_W{rf_q[{sxw_idx[IDX_W-1:1], 1'b1}][WORD_W-1]}};
        breg     = {1'b0, byte_idx[IDX_W-2:0]};

        // lowest priority first; later steps overwrite earlier ones
        if (sxl_en && sxl_idx[1:0] == 2'd0) begin
            rf_w[{sxl_idx[IDX_W-1:2], 2'd0}] = sxl_fill;
            rf_w[{sxl_idx[IDX_W-1:2], 2'd1}] = sxl_fill;
        end
        if (sxw_en && !sxw_idx[0])
            rf_w[{sxw_idx[IDX_W-1:1], 1'b0}] = sxw_fill;
        if (quad_en && quad_idx[1:0] == 2'd0)
            for (int k = 0; k < QUAD_N; k++)
                rf_w[{quad_idx[IDX_W-1:2], k[1:0]}] = quad_data[(QUAD_N-1-k)*WORD_W +: WORD_W];
        if (pair_en && !pair_idx[0]) begin
            rf_w[{pair_idx[IDX_W-1:1], 1'b0}] = pair_data[PAIR_W-1:WORD_W];
            rf_w[{pair_idx[IDX_W-1:1], 1'b1}] = pair_data[WORD_W-1:0];
        end
        if (word_en)
            rf_w[word_idx] = word_data;
        if (byte_en) begin
            if (byte_idx[IDX_W-1])
                rf_w[breg][BYTE_W-1:0] = byte_data;
            else
                rf_w[breg][WORD_W-1:BYTE_W] = byte_data;
        end
    end
endmodule

// File: rtl/mwrb_mode_swap.sv
module mwrb_mode_swap
    import mwrb_pkg::*;
(
    input  logic   sys_req,
    input  logic   sys_q,
    input  word_t  sp_cur,
    input  word_t  sg_cur,
    input  word_t  sp_sys_q,
    input  word_t  sp_nrm_q,
    input  seg_t   sg_sys_q,
    input  seg_t   sg_nrm_q,
    output logic   swap_go,
    output word_t  sp_new,
    output word_t  sg_new,
    output word_t  sp_sys_d,
    output word_t  sp_nrm_d,
    output seg_t   sg_sys_d,
    output seg_t   sg_nrm_d
);
    logic enter, leave;

    always_comb begin
        enter    = sys_req & ~sys_q;
        leave    = ~sys_req & sys_q;
        swap_go  = enter | leave;
        sp_sys_d = sp_sys_q;
        sp_nrm_d = sp_nrm_q;
        sg_sys_d = sg_sys_q;
        sg_nrm_d = sg_nrm_q;
        sp_new   = sp_cur;
        sg_new   = sg_cur;
        if (enter) begin
            sp_nrm_d = sp_cur;
            sg_nrm_d = sg_cur[SEG_LSB +: SEG_W];
            sp_new   = sp_sys_q;
            sg_new   = '0;
            sg_new[SEG_LSB +: SEG_W] = sg_sys_q;
        end else if (leave) begin
            sp_sys_d = sp_cur;
            sg_sys_d = sg_cur[SEG_LSB +: SEG_W];
            sp_new   = sp_nrm_q;
            sg_new   = '0;
            sg_new[SEG_LSB +: SEG_W] = sg_nrm_q;
        end
    end
endmodule

// File: rtl/mwreg_bank.sv
module mwreg_bank
    import mwrb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sys_mode,
    input  logic [IDX_W-1:0]     rd_byte_idx,
    output logic [BYTE_W-1:0]    rd_byte_data,
    input  logic [IDX_W-1:0]     rd_word_idx,
    output logic [WORD_W-1:0]    rd_word_data,
    input  logic [IDX_W-1:0]     rd_pair_idx,
    output logic [PAIR_W-1:0]    rd_pair_data,
    output logic                 rd_pair_bad,
    input  logic [IDX_W-1:0]     rd_quad_idx,
    output logic [QUAD_W-1:0]    rd_quad_data,
    output logic                 rd_quad_bad,
    input  logic                 wr_byte_en,
    input  logic [IDX_W-1:0]     wr_byte_idx,
    input  logic [BYTE_W-1:0]    wr_byte_data,
    input  logic                 wr_word_en,
    input  logic [IDX_W-1:0]     wr_word_idx,
    input  logic [WORD_W-1:0]    wr_word_data,
    input  logic                 wr_pair_en,
    input  logic [IDX_W-1:0]     wr_pair_idx,
    input  logic [PAIR_W-1:0]    wr_pair_data,
    input  logic                 wr_quad_en,
    input  logic [IDX_W-1:0]     wr_quad_idx,
    input  logic [QUAD_W-1:0]    wr_quad_data,
    input  logic                 sxw_en,
    input  logic [IDX_W-1:0]     sxw_idx,
    input  logic                 sxl_en,
    input  logic [IDX_W-1:0]     sxl_idx
);
    bank_t st_q, st_d;
    file_t rf_w;
    logic  swap_go;
    word_t sp_new, sg_new, sp_sys_n, sp_nrm_n;
    seg_t  sg_sys_n, sg_nrm_n;

    // views of the state for the bound checker
    file_t file_q;
    logic  sys_q;
    word_t sp_sys_q, sp_nrm_q;
    seg_t  sg_sys_q, sg_nrm_q;
    assign file_q   = st_q.regs;
    assign sys_q    = st_q.sys;
    assign sp_sys_q = st_q.sp_sys;
    assign sp_nrm_q = st_q.sp_nrm;
    assign sg_sys_q = st_q.sg_sys;
    assign sg_nrm_q = st_q.sg_nrm;

    mwrb_rd_mux u_rd (
        .rf     (st_q.regs),
        .b_idx  (rd_byte_idx), .b_data (rd_byte_data),
        .w_idx  (rd_word_idx), .w_data (rd_word_data),
        .p_idx  (rd_pair_idx), .p_data (rd_pair_data), .p_bad (rd_pair_bad),
        .q_idx  (rd_quad_idx), .q_data (rd_quad_data), .q_bad (rd_quad_bad)
    );

    mwrb_wr_merge u_wr (
        .rf_q      (st_q.regs),
        .byte_en   (wr_byte_en), .byte_idx (wr_byte_idx), .byte_data (wr_byte_data),
        .word_en   (wr_word_en), .word_idx (wr_word_idx), .word_data (wr_word_data),
        .pair_en   (wr_pair_en), .pair_idx (wr_pair_idx), .pair_data (wr_pair_data),
        .quad_en   (wr_quad_en), .quad_idx (wr_quad_idx), .quad_data (wr_quad_data),
        .sxw_en    (sxw_en),     .sxw_idx  (sxw_idx),
        .sxl_en    (sxl_en),     .sxl_idx  (sxl_idx),
        .rf_w      (rf_w)
    );

    mwrb_mode_swap u_swap (
        .sys_req  (sys_mode),
        .sys_q    (st_q.sys),
        .sp_cur   (st_q.regs[SP_REG]),
        .sg_cur   (st_q.regs[SG_REG]),
        .sp_sys_q (st_q.sp_sys),
        .sp_nrm_q (st_q.sp_nrm),
        .sg_sys_q (st_q.sg_sys),
        .sg_nrm_q (st_q.sg_nrm),
        .swap_go  (swap_go),
        .sp_new   (sp_new),
        .sg_new   (sg_new),
        .sp_sys_d (sp_sys_n),
        .sp_nrm_d (sp_nrm_n),
        .sg_sys_d (sg_sys_n),
        .sg_nrm_d (sg_nrm_n)
    );

    always_comb begin
        st_d        = st_q;
        st_d.regs   = rf_w;
        st_d.sp_sys = sp_sys_n;
        st_d.sp_nrm = sp_nrm_n;
        st_d.sg_sys = sg_sys_n;
        st_d.sg_nrm = sg_nrm_n;
        st_d.sys    = sys_mode;
        if (swap_go) begin
            st_d.regs[SP_REG] = sp_new;
            st_d.regs[SG_REG] = sg_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mwrb_chk.sv
module mwrb_chk
    import mwrb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sys_mode,
    input logic              sys_q,
    input file_t             file_q,
    input word_t             sp_sys_q,
    input word_t             sp_nrm_q,
    input seg_t              sg_sys_q,
    input seg_t              sg_nrm_q,
    input logic              wr_byte_en,
    input logic [IDX_W-1:0]  wr_byte_idx,
    input logic              wr_word_en,
    input logic              wr_pair_en,
    input logic [IDX_W-1:0]  wr_pair_idx,
    input logic              wr_quad_en,
    input logic              sxw_en,
    input logic [IDX_W-1:0]  sxw_idx,
    input logic              sxl_en
);
    function automatic logic [BYTE_W-1:0] other_half(file_t f, logic [IDX_W-1:0] i);
        word_t w;
        w = f[{1'b0, i[IDX_W-2:0]}];
        return i[IDX_W-1] ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

    logic steady, byte_only, pair_only, sxw_only;
    assign steady    = (sys_mode == sys_q);
    assign byte_only = wr_byte_en & ~wr_word_en & ~wr_pair_en & ~wr_quad_en & ~sxw_en & ~sxl_en;
    assign pair_only = wr_pair_en & ~wr_byte_en & ~wr_word_en & ~wr_quad_en & ~sxw_en & ~sxl_en;
    assign sxw_only  = sxw_en & ~wr_byte_en & ~wr_word_en & ~wr_pair_en & ~wr_quad_en & ~sxl_en;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (file_q == '0 && sp_sys_q == '0 && sp_nrm_q == '0
                           && sg_sys_q == '0 && sg_nrm_q == '0));

    // R3
    byte_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_only |=> other_half(file_q, $past(wr_byte_idx)) == $past(other_half(file_q, wr_byte_idx)));

    // R5
    pair_odd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_only && wr_pair_idx[0] && steady) |=> $stable(file_q));

    // R7
    sxw_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sxw_only && !sxw_idx[0]) |=>
            file_q[$past(sxw_idx)] == {WORD_W{$past(file_q[sxw_idx | 4'd1][WORD_W-1])}});

    // R9
    enter_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_mode && !sys_q) |=> (file_q[SP_REG] == $past(sp_sys_q)
            && sp_nrm_q == $past(file_q[SP_REG])
            && sg_nrm_q == $past(file_q[SG_REG][SEG_LSB +: SEG_W])));

    // R10
    leave_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_mode && sys_q) |=> (file_q[SP_REG] == $past(sp_nrm_q)
            && sp_sys_q == $past(file_q[SP_REG])
            && sg_sys_q == $past(file_q[SG_REG][SEG_LSB +: SEG_W])));

    // R11
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        steady |=> ($stable(sp_sys_q) && $stable(sp_nrm_q)
                    && $stable(sg_sys_q) && $stable(sg_nrm_q)));

    // R11
    mode_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sys_q == $past(sys_mode));
endmodule

bind mwreg_bank mwrb_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_mode    (sys_mode),
    .sys_q       (sys_q),
    .file_q      (file_q),
    .sp_sys_q    (sp_sys_q),
    .sp_nrm_q    (sp_nrm_q),
    .sg_sys_q    (sg_sys_q),
    .sg_nrm_q    (sg_nrm_q),
    .wr_byte_en  (wr_byte_en),
    .wr_byte_idx (wr_byte_idx),
    .wr_word_en  (wr_word_en),
    .wr_pair_en  (wr_pair_en),
    .wr_pair_idx (wr_pair_idx),
    .wr_quad_en  (wr_quad_en),
    .sxw_en      (sxw_en),
    .sxw_idx     (sxw_idx),
    .sxl_en      (sxl_en)
);

// File: tb/mwreg_bank_tb.sv
`timescale 1ns/1ps
module mwreg_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_mode = 1'b0;
    logic [3:0]  rd_byte_idx = '0, rd_word_idx = '0, rd_pair_idx = '0, rd_quad_idx = '0;
    logic [7:0]  rd_byte_data;
    logic [15:0] rd_word_data;
    logic [31:0] rd_pair_data;
    logic [63:0] rd_quad_data;
    logic        rd_pair_bad, rd_quad_bad;
    logic        wr_byte_en = 0, wr_word_en = 0, wr_pair_en = 0, wr_quad_en = 0, sxw_en = 0, sxl_en = 0;
    logic [3:0]  wr_byte_idx = '0, wr_word_idx = '0, wr_pair_idx = '0, wr_quad_idx = '0, sxw_idx = '0, sxl_idx = '0;
    logic [7:0]  wr_byte_data = '0;
    logic [15:0] wr_word_data = '0;
    logic [31:0] wr_pair_data = '0;
    logic [63:0] wr_quad_data = '0;

    always #2.5 clk = ~clk;

    mwreg_bank u_dut (.*);

    // port codes: 0 word, 1 byte, 2 pair, 3 quad, 4 pair_bad, 5 quad_bad
    typedef struct { string tag; int port; logic [63:0] exp; } sb_item_t;
    sb_item_t sbq[$];
    event     sb_ev;
    int       n_chk = 0, n_err = 0;
    bit       done = 0;

    initial forever begin
        @(sb_ev);
        while (sbq.size() > 0) begin
            sb_item_t it;
            logic [63:0] act;
            it = sbq.pop_front();
            case (it.port)
                0: act = {48'd0, rd_word_data};
                1: act = {56'd0, rd_byte_data};
                2: act = {32'd0, rd_pair_data};
                3: act = rd_quad_data;
                4: act = {63'd0, rd_pair_bad};
                default: act = {63'd0, rd_quad_bad};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk(input string tag, input int port, input logic [3:0] idx, input logic [63:0] exp);
        case (port)
            0: rd_word_idx = idx;
            1: rd_byte_idx = idx;
            2, 4: rd_pair_idx = idx;
            default: rd_quad_idx = idx;
        endcase
        #0.2;
        sbq.push_back('{tag, port, exp});
        -> sb_ev;
        wait (sbq.size() == 0);
    endtask

    task automatic wr_word(input logic [3:0] i, input logic [15:0] d);
        @(negedge clk); wr_word_idx = i; wr_word_data = d; wr_word_en = 1;
        @(negedge clk); wr_word_en = 0;
    endtask
    task automatic wr_byte(input logic [3:0] i, input logic [7:0] d);
        @(negedge clk); wr_byte_idx = i; wr_byte_data = d; wr_byte_en = 1;
        @(negedge clk); wr_byte_en = 0;
    endtask
    task automatic wr_pair(input logic [3:0] i, input logic [31:0] d);
        @(negedge clk); wr_pair_idx = i; wr_pair_data = d; wr_pair_en = 1;
        @(negedge clk); wr_pair_en = 0;
    endtask
    task automatic wr_quad(input logic [3:0] i, input logic [63:0] d);
        @(negedge clk); wr_quad_idx = i; wr_quad_data = d; wr_quad_en = 1;
        @(negedge clk); wr_quad_en = 0;
    endtask
    task automatic do_sxw(input logic [3:0] i);
        @(negedge clk); sxw_idx = i; sxw_en = 1;
        @(negedge clk); sxw_en = 0;
    endtask
    task automatic do_sxl(input logic [3:0] i);
        @(negedge clk); sxl_idx = i; sxl_en = 1;
        @(negedge clk); sxl_en = 0;
    endtask
    task automatic set_mode(input logic m);
        @(negedge clk); sys_mode = m;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R1 reset R0", 0, 4'd0, 64'h0);
        chk("R1 reset R15", 0, 4'd15, 64'h0);
        chk("R1 reset quad 12", 3, 4'd12, 64'h0);

        wr_word(4'd3, 16'h1234);
        chk("R4 word R3", 0, 4'd3, 64'h1234);
        wr_word(4'd2, 16'h5A3C);
        wr_byte(4'hA, 8'hC7);
        chk("R3 low byte write keeps high", 0, 4'd2, 64'h5AC7);
        wr_byte(4'h2, 8'h19);
        chk("R3 high byte write keeps low", 0, 4'd2, 64'h19C7);
        chk("R2 byte read high R2", 1, 4'h2, 64'h19);
        chk("R2 byte read low R2", 1, 4'hA, 64'hC7);
        chk("R2 byte read high R3", 1, 4'h3, 64'h12);

        wr_pair(4'd4, 32'hDEAD_BEEF);
        chk("R5 pair even reg", 0, 4'd4, 64'hDEAD);
        chk("R5 pair odd reg", 0, 4'd5, 64'hBEEF);
        chk("R5 pair read", 2, 4'd4, 64'hDEAD_BEEF);
        wr_pair(4'd5, 32'h0123_4567);
        chk("R5 odd pair write ignored R4", 0, 4'd4, 64'hDEAD);
        chk("R5 odd pair write ignored R5", 0, 4'd5, 64'hBEEF);
        chk("R5 odd pair write ignored R6", 0, 4'd6, 64'h0);
        chk("R5 odd pair bad flag", 4, 4'd5, 64'h1);
        chk("R5 odd pair data zero", 2, 4'd5, 64'h0);
        chk("R5 even pair flag clear", 4, 4'd4, 64'h0);

        wr_quad(4'd8, 64'h1111_2222_3333_4444);
        chk("R6 quad top word", 0, 4'd8, 64'h1111);
        chk("R6 quad bottom word", 0, 4'd11, 64'h4444);
        chk("R6 quad read", 3, 4'd8, 64'h1111_2222_3333_4444);
        wr_quad(4'd10, 64'hAAAA_BBBB_CCCC_DDDD);
        chk("R6 misaligned quad write ignored", 3, 4'd8, 64'h1111_2222_3333_4444);
        chk("R6 misaligned quad write ignored R12", 0, 4'd12, 64'h0);
        chk("R6 misaligned quad bad flag", 5, 4'd10, 64'h1);
        chk("R6 misaligned quad data zero", 3, 4'd9, 64'h0);

        wr_word(4'd7, 16'h8001);
        do_sxw(4'd6);
        chk("R7 sign-extend word negative", 0, 4'd6, 64'hFFFF);
        wr_word(4'd7, 16'h0001);
        do_sxw(4'd6);
        chk("R7 sign-extend word positive", 0, 4'd6, 64'h0);
        wr_word(4'd7, 16'h8000);
        do_sxw(4'd7);
        chk("R7 odd sign-extend ignored", 0, 4'd6, 64'h0);

        wr_word(4'd14, 16'h8000);
        do_sxl(4'd12);
        chk("R8 sign-extend long negative", 3, 4'd12, 64'hFFFF_FFFF_8000_0000);
        wr_word(4'd14, 16'h7F00);
        do_sxl(4'd12);
        chk("R8 sign-extend long positive", 3, 4'd12, 64'h0000_0000_7F00_0000);
        wr_word(4'd14, 16'h8000);
        do_sxl(4'd13);
        chk("R8 misaligned sign-extend long ignored", 3, 4'd12, 64'h0000_0000_8000_0000);

        // R12: read of a register under write returns the old value
        @(negedge clk);
        wr_word_idx = 4'd3; wr_word_data = 16'hBEEF; wr_word_en = 1;
        chk("R12 read during write old value", 0, 4'd3, 64'h1234);
        @(negedge clk); wr_word_en = 0;
        chk("R12 value after write", 0, 4'd3, 64'hBEEF);

        // R13: word beats pair on an overlapping register
        @(negedge clk);
        wr_pair_idx = 4'd4; wr_pair_data = 32'hAAAA_BBBB; wr_pair_en = 1;
        wr_word_idx = 4'd4; wr_word_data = 16'hCCCC; wr_word_en = 1;
        @(negedge clk); wr_pair_en = 0; wr_word_en = 0;
        chk("R13 word over pair", 2, 4'd4, 64'hCCCC_BBBB);
        @(negedge clk);
        wr_byte_idx = 4'hC; wr_byte_data = 8'h5E; wr_byte_en = 1;
        wr_word_idx = 4'd4; wr_word_data = 16'h1357; wr_word_en = 1;
        @(negedge clk); wr_byte_en = 0; wr_word_en = 0;
        chk("R13 byte over word", 0, 4'd4, 64'h135E);

        wr_word(4'd15, 16'h1111);
        wr_word(4'd14, 16'h2A55);
        set_mode(1'b1);
        chk("R9 enter system pointer from reset copy", 0, 4'd15, 64'h0);
        chk("R9 enter system segment from reset copy", 0, 4'd14, 64'h0);
        wr_word(4'd15, 16'h3333);
        wr_word(4'd14, 16'h1500);
        repeat (3) @(negedge clk);
        chk("R11 no swap while mode steady R15", 0, 4'd15, 64'h3333);
        chk("R11 no swap while mode steady R14", 0, 4'd14, 64'h1500);
        set_mode(1'b0);
        chk("R10 leave system pointer", 0, 4'd15, 64'h1111);
        chk("R10 leave system segment", 0, 4'd14, 64'h2A00);
        set_mode(1'b1);
        chk("R9 enter system pointer", 0, 4'd15, 64'h3333);
        chk("R9 enter system segment", 0, 4'd14, 64'h1500);

        // R13: swap overrides a same-edge write and saves the pre-edge value
        @(negedge clk);
        sys_mode = 1'b0; wr_word_idx = 4'd15; wr_word_data = 16'h7777; wr_word_en = 1;
        @(negedge clk); wr_word_en = 0;
        chk("R13 swap overrides R15 write", 0, 4'd15, 64'h1111);
        set_mode(1'b1);
        chk("R13 saved pointer is pre-edge value", 0, 4'd15, 64'h3333);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not complete (actual hung, expected done)");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule